// File: doc/BRIEF.md
# Line-Interface Control Register File

This block is the byte-wide register file of a line-interface controller. It receives bytes that a serial shifter upstream has already assembled, together with a strobe that marks the first byte of each transaction. Each transaction opens with a command byte. That byte carries a write flag and a register address.

The block holds three pieces of storage:
- a control register that drives the transmitter and receiver mode pins;
- a receive equalizer gain register;
- an indirect coefficient RAM that is reached through a location byte.

The block also owns a sticky alarm status bit. The bit latches when the receiver reports an all-ones line condition and drives an interrupt, which software can mask. Reads come back as a one-cycle response pulse that carries a data byte.

Top module: `lic_regfile`

## Requirements
- R1: Reset state:
  - register 0x11 reads 0x00 and register 0x12 reads 0x01;
  - every coefficient location reads 0x00;
  - `irq`, `rd_vld` and all mode outputs are 0;
  - `eq_gain` is 1.
- R2: A command byte is accepted only when `txn_start` and `byte_vld` are high in the same cycle. In that byte:
  - bit 7 = 1 means write and 0 means read;
  - bits 4:0 are the register address;
  - bits 6:5 are ignored.
  A byte that arrives without `txn_start` while no sequence is open changes nothing.
- R3: A write to 0x11 takes effect one cycle after its data byte, with this mapping:
  - bit 6 drives `pulse_from_ram`;
  - bit 4 drives `loop_dn`;
  - bit 3 drives `loop_up`;
  - bit 2 drives `rx_pwdn`;
  - bit 1 drives `tx_hiz`;
  - bits 5 and 0 are reserved: they always store 0 and read back as 0.
- R4: When `ones_det` is sampled high, the alarm bit (bit 7 of a 0x11 read) is 1 from the next cycle on.
- R5: The alarm bit clears on the first read command, to any address, that is accepted while `ones_det` is low. A read accepted while `ones_det` is high leaves the bit set. The read that clears the bit still reports the value the bit had before clearing.
- R6: `irq` equals alarm AND NOT mask, combinationally. The mask is bit 7 of the most recent write to 0x11, and 1 masks.
- R7: A write to 0x12 stores bits 4:0, which drive `eq_gain`. A read of 0x12 returns those bits with bits 7:5 as 0.
- R8: A coefficient write is three bytes: a command 0x93 (write flag set, address 0x13), then a location byte, then a data byte. Locations above 0x29 cause the data byte to be ignored.
- R9: A coefficient read is two bytes: a read command to 0x13, then a location byte. `rd_vld` pulses one cycle after the location byte, carrying the stored value, or 0x00 for a location above 0x29.
- R10: A read command to any other address gives a `rd_vld` pulse one cycle after the command byte. Addresses other than 0x11, 0x12 and 0x13 read 0x00, and writes to them change nothing.
- R11: A new `txn_start` abandons any partial sequence, with or without a byte in that cycle. Bytes that arrive after a sequence has completed are ignored until the next `txn_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_start | input | 1 | Marks the first byte of a transaction; alone, it abandons a sequence |
| byte_vld | input | 1 | `byte_in` carries a byte this cycle |
| byte_in | input | 8 | Assembled serial byte |
| ones_det | input | 1 | Receiver sees an all-ones pattern |
| rd_vld | output | 1 | Read response strobe |
| rd_data | output | 8 | Read response data |
| irq | output | 1 | Active-high alarm interrupt |
| pulse_from_ram | output | 1 | Transmit pulse shape taken from the coefficient RAM |
| loop_dn | output | 1 | Repeat the loop-down code |
| loop_up | output | 1 | Repeat the loop-up code |
| rx_pwdn | output | 1 | Receiver power down |
| tx_hiz | output | 1 | Transmitter high impedance |
| eq_gain | output | 5 | Receive equalizer gain code |

## Verification
A wrong alarm or mask state shows on `irq` in the same cycle, because that output is combinational. A corrupted control or gain value shows on the mode pins one cycle after the byte that wrote it. A sequencer that has lost its place, or a RAM word that was written when it should not have been, stays hidden until a later read. That read reports it one cycle after its last byte. For this reason, every abandoned or out-of-range write is followed by a read-back of the location it could have touched.

// File: rtl/lic_pkg.sv
package lic_pkg;
   typedef enum logic [2:0] {
      SQ_IDLE,
      SQ_DATA,
      SQ_LOC,
      SQ_RDATA,
      SQ_DONE
   } seq_st_t;
endpackage

// File: rtl/lic_cmd_seq.sv
module lic_cmd_seq
   import lic_pkg::*;
#(
   parameter int DW = 8,
   parameter int AW = 5,
   parameter int DEPTH = 42,
   parameter logic [AW-1:0] RAM_ADDR = 5'h13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sot,
   input  logic          vld,
   input  logic [DW-1:0] din,
   output logic          cmd_rd,
   output logic          reg_rd,
   output logic [AW-1:0] rd_addr,
   output logic          reg_we,
   output logic [AW-1:0] wr_addr,
   output logic          ram_rd,
   output logic          ram_we,
   output logic [DW-1:0] ram_idx
);
   localparam int WR_BIT = DW - 1;
   localparam logic [DW-1:0] LAST_LOC = DW'(DEPTH - 1);

   seq_st_t st_q, st_d;
   logic wr_q;
   logic [AW-1:0] addr_q;
   logic [DW-1:0] loc_q;
   logic cmd_fire, cmd_wr, cmd_ram, dat_fire;

   assign cmd_fire = sot & vld;
   assign cmd_wr   = din[WR_BIT];
   assign cmd_ram  = (din[AW-1:0] == RAM_ADDR);
   assign dat_fire = vld & ~sot;

   always_comb begin
      st_d = st_q;
      if (sot) begin
         if (!vld)         st_d = SQ_IDLE;
         else if (cmd_ram) st_d = SQ_LOC;
         else if (cmd_wr)  st_d = SQ_DATA;
         else              st_d = SQ_DONE;
      end else if (vld) begin
         unique case (st_q)
            SQ_DATA:  st_d = SQ_DONE;
            SQ_LOC:   st_d = wr_q ? SQ_RDATA : SQ_DONE;
            SQ_RDATA: st_d = SQ_DONE;
            default:  st_d = st_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         wr_q   <= 1'b0;
         addr_q <= '0;
         loc_q  <= '0;
      end else begin
         st_q <= st_d;
         if (cmd_fire) begin
            wr_q   <= cmd_wr;
            addr_q <= din[AW-1:0];
         end
         if (dat_fire && st_q == SQ_LOC) loc_q <= din;
      end
   end

   assign cmd_rd  = cmd_fire & ~cmd_wr;
   assign reg_rd  = cmd_rd & ~cmd_ram;
   assign rd_addr = din[AW-1:0];
   assign reg_we  = dat_fire & (st_q == SQ_DATA);
   assign wr_addr = addr_q;
   assign ram_rd  = dat_fire & (st_q == SQ_LOC) & ~wr_q;
   assign ram_we  = dat_fire & (st_q == SQ_RDATA) & (loc_q <= LAST_LOC);
   assign ram_idx = (st_q == SQ_LOC) ? din : loc_q;

   // R11
   excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_rd, reg_we, ram_rd, ram_we}));
endmodule

// File: rtl/lic_alarm.sv
module lic_alarm (
   input  logic clk,
   input  logic rst_n,
   input  logic ones_det,
   input  logic rd_evt,
   input  logic mask_we,
   input  logic mask_d,
   output logic ais,
   output logic irq
);
   logic ais_q, mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ais_q  <= 1'b0;
         mask_q <= 1'b0;
      end else begin
         if (ones_det)    ais_q <= 1'b1;
         else if (rd_evt) ais_q <= 1'b0;
         if (mask_we) mask_q <= mask_d;
      end
   end

   assign ais = ais_q;
   assign irq = ais_q & ~mask_q;

   // R4
   ais_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ones_det |=> ais_q);
   // R5
   ais_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ais_q && !rd_evt) |=> ais_q);
   // R5
   ais_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_evt && !ones_det) |=> !ais_q);
endmodule

// File: rtl/lic_coef_ram.sv
module lic_coef_ram #(
   parameter int DW = 8,
   parameter int DEPTH = 42,
   parameter bit CLR_ON_RST = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] idx,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata
);
   localparam int AIW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [DW-1:0] LAST_LOC = DW'(DEPTH - 1);

   logic [DW-1:0] mem [DEPTH];

   if (CLR_ON_RST) begin : g_clr
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
         end else if (we) begin
            mem[idx[AIW-1:0]] <= wdata;
         end
      end
   end else begin : g_keep
      always_ff @(posedge clk) begin
         if (we) mem[idx[AIW-1:0]] <= wdata;
      end
   end

   assign rdata = (idx <= LAST_LOC) ? mem[idx[AIW-1:0]] : '0;

   // R8
   ram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (idx <= LAST_LOC));
endmodule

// File: rtl/lic_regfile.sv
module lic_regfile #(
   parameter int DW = 8,
   parameter int AW = 5,
   parameter int GW = 5,
   parameter int DEPTH = 42,
   parameter logic [AW-1:0] CTRL_ADDR = 5'h11,
   parameter logic [AW-1:0] GAIN_ADDR = 5'h12,
   parameter logic [AW-1:0] RAM_ADDR = 5'h13,
   parameter logic [GW-1:0] GAIN_RST = 5'd1,
   parameter bit RAM_CLR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          txn_start,
   input  logic          byte_vld,
   input  logic [DW-1:0] byte_in,
   input  logic          ones_det,
   output logic          rd_vld,
   output logic [DW-1:0] rd_data,
   output logic          irq,
   output logic          pulse_from_ram,
   output logic          loop_dn,
   output logic          loop_up,
   output logic          rx_pwdn,
   output logic          tx_hiz,
   output logic [GW-1:0] eq_gain
);
   localparam int B_RAMP = 6;
   localparam int B_LDN  = 4;
   localparam int B_LUP  = 3;
   localparam int B_PWDN = 2;
   localparam int B_HIZ  = 1;
   localparam logic [DW-2:0] CTRL_WMASK = (DW-1)'((1 << B_RAMP) | (1 << B_LDN) |
                                                  (1 << B_LUP) | (1 << B_PWDN) | (1 << B_HIZ));

   if (DW < 8) begin : g_bad_dw
      $error("lic_regfile: DW must be at least 8");
   end
   if (GW > DW - 1) begin : g_bad_gw
      $error("lic_regfile: GW must leave the top bit free");
   end
   if (DEPTH < 2 || DEPTH > (1 << DW)) begin : g_bad_depth
      $error("lic_regfile: DEPTH out of range for the location byte");
   end

   logic cmd_rd, reg_rd, reg_we, ram_rd, ram_we;
   logic [AW-1:0] rd_addr, wr_addr;
   logic [DW-1:0] ram_idx, ram_rdata, reg_val;
   logic [DW-2:0] ctrl_q;
   logic [GW-1:0] gain_q;
   logic ais, ctrl_we;
   logic rd_vld_q;
   logic [DW-1:0] rd_data_q;

   lic_cmd_seq #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .RAM_ADDR(RAM_ADDR)) u_seq (
      .clk(clk), .rst_n(rst_n), .sot(txn_start), .vld(byte_vld), .din(byte_in),
      .cmd_rd(cmd_rd), .reg_rd(reg_rd), .rd_addr(rd_addr), .reg_we(reg_we),
      .wr_addr(wr_addr), .ram_rd(ram_rd), .ram_we(ram_we), .ram_idx(ram_idx)
   );

   assign ctrl_we = reg_we & (wr_addr == CTRL_ADDR);

   lic_alarm u_alarm (
      .clk(clk), .rst_n(rst_n), .ones_det(ones_det), .rd_evt(cmd_rd),
      .mask_we(ctrl_we), .mask_d(byte_in[DW-1]), .ais(ais), .irq(irq)
   );

   lic_coef_ram #(.DW(DW), .DEPTH(DEPTH), .CLR_ON_RST(RAM_CLR)) u_ram (
      .clk(clk), .rst_n(rst_n), .we(ram_we), .idx(ram_idx), .wdata(byte_in),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         gain_q <= GAIN_RST;
      end else if (reg_we) begin
         if (wr_addr == CTRL_ADDR) ctrl_q <= byte_in[DW-2:0] & CTRL_WMASK;
         if (wr_addr == GAIN_ADDR) gain_q <= byte_in[GW-1:0];
      end
   end

   always_comb begin
      reg_val = '0;
      if (rd_addr == CTRL_ADDR)      reg_val = {ais, ctrl_q};
      else if (rd_addr == GAIN_ADDR) reg_val = DW'(gain_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_vld_q  <= 1'b0;
         rd_data_q <= '0;
      end else begin
         rd_vld_q  <= reg_rd | ram_rd;
         rd_data_q <= ram_rd ? ram_rdata : (reg_rd ? reg_val : '0);
      end
   end

   assign rd_vld         = rd_vld_q;
   assign rd_data        = rd_data_q;
   assign pulse_from_ram = ctrl_q[B_RAMP];
   assign loop_dn        = ctrl_q[B_LDN];
   assign loop_up        = ctrl_q[B_LUP];
   assign rx_pwdn        = ctrl_q[B_PWDN];
   assign tx_hiz         = ctrl_q[B_HIZ];
   assign eq_gain        = gain_q;

   // R10
   rd_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd || ram_rd) |=> rd_vld);
   // R10
   rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_rd || ram_rd) |=> !rd_vld);
endmodule

// File: tb/sim_lic_regfile.sv
module sim_lic_regfile;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic txn_start = 1'b0, byte_vld = 1'b0, ones_det = 1'b0;
   logic [7:0] byte_in = 8'h00;
   logic rd_vld, irq, pulse_from_ram, loop_dn, loop_up, rx_pwdn, tx_hiz;
   logic [7:0] rd_data;
   logic [4:0] eq_gain;

   int checks = 0, errors = 0;
   bit chk_on = 1'b0, done = 1'b0;

   always #5 clk = ~clk;

   lic_regfile u0 (
      .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .byte_vld(byte_vld),
      .byte_in(byte_in), .ones_det(ones_det), .rd_vld(rd_vld), .rd_data(rd_data),
      .irq(irq), .pulse_from_ram(pulse_from_ram), .loop_dn(loop_dn), .loop_up(loop_up),
      .rx_pwdn(rx_pwdn), .tx_hiz(tx_hiz), .eq_gain(eq_gain)
   );

   // behavioural reference: phase 0 idle, 1 reg data, 2 location, 3 coef data, 4 finished
   int m_phase = 0;
   bit m_wr = 0, m_ais = 0, m_mask = 0, m_rdv = 0;
   int m_addr = 0, m_loc = 0;
   bit [7:0] m_ctrl = 0, m_rdd = 0;
   bit [4:0] m_gain = 1;
   bit [7:0] m_ram [42];

   function automatic bit [7:0] m_regval(int a);
      if (a == 'h11) return {m_ais, m_ctrl[6:0]};
      if (a == 'h12) return {3'b000, m_gain};
      return 8'h00;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_wr = 0; m_ais = 0; m_mask = 0; m_rdv = 0; m_rdd = 0;
         m_addr = 0; m_loc = 0; m_ctrl = 0; m_gain = 1;
         foreach (m_ram[i]) m_ram[i] = 0;
      end else begin
         bit clr_evt;
         bit nv;
         bit [7:0] nd;
         clr_evt = 0; nv = 0; nd = 0;
         if (txn_start) begin
            if (byte_vld) begin
               m_wr = byte_in[7];
               m_addr = int'(byte_in[4:0]);
               if (!m_wr) clr_evt = 1;
               if (m_addr == 'h13) m_phase = 2;
               else if (m_wr) m_phase = 1;
               else begin
                  m_phase = 4; nv = 1; nd = m_regval(m_addr);
               end
            end else m_phase = 0;
         end else if (byte_vld) begin
            if (m_phase == 1) begin
               if (m_addr == 'h11) begin
                  m_ctrl = byte_in & 8'h5E; m_mask = byte_in[7];
               end else if (m_addr == 'h12) m_gain = byte_in[4:0];
               m_phase = 4;
            end else if (m_phase == 2) begin
               if (m_wr) begin
                  m_loc = int'(byte_in); m_phase = 3;
               end else begin
                  nv = 1; nd = (byte_in < 42) ? m_ram[byte_in] : 8'h00; m_phase = 4;
               end
            end else if (m_phase == 3) begin
               if (m_loc < 42) m_ram[m_loc] = byte_in;
               m_phase = 4;
            end
         end
         if (ones_det) m_ais = 1;
         else if (clr_evt) m_ais = 0;
         m_rdv = nv; m_rdd = nd;
      end
   end

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // per-cycle comparison against the reference
   always @(negedge clk) begin
      if (chk_on && !done) begin
         chk(irq === (m_ais & ~m_mask), "R6 irq", int'(irq), int'(m_ais & ~m_mask));
         chk({pulse_from_ram, loop_dn, loop_up, rx_pwdn, tx_hiz} ===
             {m_ctrl[6], m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1]}, "R3 mode pins",
             int'({pulse_from_ram, loop_dn, loop_up, rx_pwdn, tx_hiz}),
             int'({m_ctrl[6], m_ctrl[4], m_ctrl[3], m_ctrl[2], m_ctrl[1]}));
         chk(eq_gain === m_gain, "R7 gain", int'(eq_gain), int'(m_gain));
         chk(rd_vld === m_rdv, "R10 rd_vld", int'(rd_vld), int'(m_rdv));
         if (m_rdv) chk(rd_data === m_rdd, "R9 rd_data", int'(rd_data), int'(m_rdd));
      end
   end

   task automatic put(bit s, bit v, bit [7:0] b);
      @(negedge clk);
      txn_start = s; byte_vld = v; byte_in = b;
      @(negedge clk);
      txn_start = 0; byte_vld = 0;
   endtask

   task automatic wr_reg(bit [7:0] cmd, bit [7:0] d);
      put(1, 1, cmd);
      put(0, 1, d);
   endtask

   task automatic rd_reg(bit [7:0] cmd, bit [7:0] exp, string req);
      put(1, 1, cmd);
      chk(rd_vld === 1'b1, req, int'(rd_vld), 1);
      chk(rd_data === exp, req, int'(rd_data), int'(exp));
   endtask

   task automatic wr_coef(bit [7:0] loc, bit [7:0] d);
      put(1, 1, 8'h93);
      put(0, 1, loc);
      put(0, 1, d);
   endtask

   task automatic rd_coef(bit [7:0] loc, bit [7:0] exp, string req);
      put(1, 1, 8'h13);
      put(0, 1, loc);
      chk(rd_vld === 1'b1, req, int'(rd_vld), 1);
      chk(rd_data === exp, req, int'(rd_data), int'(exp));
   endtask

   task automatic report();
      if (!done) begin
         done = 1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(10 * 150000);
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      report();
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_on = 1;
      @(negedge clk);
      rst_n = 1;
      // R1 reset values
      chk(irq === 0 && rd_vld === 0 && eq_gain === 5'd1, "R1 reset outputs",
          int'({irq, rd_vld, eq_gain}), 1);
      rd_reg(8'h11, 8'h00, "R1 ctrl reset");
      rd_reg(8'h12, 8'h01, "R1 gain reset");
      rd_coef(8'h28, 8'h00, "R1 coef reset");
      // R3 control write, reserved bits dropped
      wr_reg(8'h91, 8'hFF);
      chk({pulse_from_ram, loop_dn, loop_up, rx_pwdn, tx_hiz} === 5'b11111, "R3 all set",
          int'({pulse_from_ram, loop_dn, loop_up, rx_pwdn, tx_hiz}), 'h1F);
      rd_reg(8'h11, 8'h5E, "R3 reserved read 0");
      wr_reg(8'h91, 8'h14);
      rd_reg(8'h11, 8'h14, "R3 loop_dn rx_pwdn");
      // R7 gain upper bits read 0
      wr_reg(8'h92, 8'hF4);
      chk(eq_gain === 5'h14, "R7 gain write", int'(eq_gain), 'h14);
      rd_reg(8'h12, 8'h14, "R7 gain read");
      // R2 bits 6:5 ignored, stray byte ignored
      wr_reg(8'hF2, 8'h03);
      rd_reg(8'h72, 8'h03, "R2 ignored bits");
      put(0, 1, 8'h09);
      rd_reg(8'h12, 8'h03, "R2 stray byte");
      // R4 R5 R6 alarm
      wr_reg(8'h91, 8'h00);
      @(negedge clk); ones_det = 1;
      @(negedge clk);
      chk(irq === 1, "R4 alarm raised", int'(irq), 1);
      rd_reg(8'h12, 8'h03, "R5 read during alarm");
      rd_reg(8'h11, 8'h80, "R5 alarm kept while present");
      ones_det = 0;
      @(negedge clk);
      chk(irq === 1, "R5 sticky", int'(irq), 1);
      rd_reg(8'h11, 8'h80, "R5 clearing read reports 1");
      chk(irq === 0, "R5 cleared", int'(irq), 0);
      rd_reg(8'h11, 8'h00, "R5 after clear");
      // R6 mask
      wr_reg(8'h91, 8'h80);
      @(negedge clk); ones_det = 1;
      @(negedge clk); ones_det = 0;
      @(negedge clk);
      chk(irq === 0, "R6 masked", int'(irq), 0);
      wr_reg(8'h91, 8'h00);
      chk(irq === 1, "R6 unmasked", int'(irq), 1);
      rd_reg(8'h11, 8'h80, "R6 alarm bit");
      // R8 R9 coefficients
      wr_coef(8'h00, 8'hA5);
      wr_coef(8'h29, 8'h3C);
      wr_coef(8'h2A, 8'h77);
      rd_coef(8'h00, 8'hA5, "R9 loc 0");
      rd_coef(8'h29, 8'h3C, "R9 loc 29");
      rd_coef(8'h2A, 8'h00, "R8 out of range");
      rd_coef(8'h0A, 8'h00, "R8 wrap not written");
      // R10 unknown addresses
      wr_reg(8'h85, 8'hFF);
      rd_reg(8'h05, 8'h00, "R10 unknown addr");
      rd_reg(8'h11, 8'h00, "R10 ctrl untouched");
      // R11 abandon
      put(1, 1, 8'h93);
      put(0, 1, 8'h05);
      put(1, 0, 8'h00);
      put(0, 1, 8'h66);
      rd_coef(8'h05, 8'h00, "R11 abandoned coef");
      put(1, 1, 8'h91);
      rd_reg(8'h12, 8'h03, "R11 restart");
      chk(loop_up === 0, "R11 no ctrl write", int'(loop_up), 0);
      wr_reg(8'h92, 8'h07);
      put(0, 1, 8'h01);
      rd_reg(8'h12, 8'h07, "R11 trailing byte");
      // mixed stream, compared each cycle
      for (int n = 0; n < 3000; n++) begin
         int r;
         r = int'($urandom);
         @(negedge clk);
         if (r[3:0] == 0) ones_det = ~ones_det;
         txn_start = (r[6:4] < 2);
         byte_vld  = r[7] | r[8];
         case (r[10:9])
            2'd0: byte_in = {r[11], r[13:12], 5'h11};
            2'd1: byte_in = {r[11], r[13:12], 5'h12};
            2'd2: byte_in = {r[11], r[13:12], 5'h13};
            default: byte_in = r[21:14] % 8'd48;
         endcase
      end
      @(negedge clk);
      txn_start = 0; byte_vld = 0;
      repeat (3) @(negedge clk);
      report();
   end
endmodule